// File: doc/BRIEF.md
# Serially Programmed Clock Fan-out Gate

This block takes one reference clock and distributes it to eighteen outputs. Each output has its own enable bit. A set bit lets the output follow the reference clock. A cleared bit holds the output low. The enable bits are loaded over a write-only two-wire serial slave interface: a start condition, the slave address with the write bit, then a stream of data bytes. Each data byte is acknowledged and mapped onto a group of outputs.

The serial lines are sampled by a fast system clock through two-stage synchronizers. Start and stop conditions are recognised as data-line edges while the serial clock is high. A completed byte updates the enable register only after its last bit has arrived. The enables are then carried into the reference-clock domain on the falling edge of that clock, so a gated output never shows a shortened pulse.

A separate output-enable input overrides everything. When it is low, the block reports every output as undriven (high impedance) and holds the clock lines low.

Top module: `clkfan_ctl`

## Requirements
- R1: After reset all outputs are enabled, so each output follows `ref_clk_i` whenever `out_en_i` is high.
- R2: A transfer addressed to 7-bit address 1101001 with a write bit (first byte 0xD2) is acknowledged: `sda_oe_o` is high during the ninth serial clock and only rises while the serial clock is low.
- R3: Any other address, and a read request (first byte 0xD3), gets no acknowledge, and the data bytes that follow change no output.
- R4: Data bytes are shifted most significant bit first. Data byte 0 bit b sets the enable of output b, and data byte 1 bit b sets the enable of output 8+b, where 1 means active.
- R5: In data byte 2, bit 7 sets output 17 and bit 6 sets output 16. Bits 5 to 0 have no effect.
- R6: Data bytes after byte 2 are acknowledged and change no output.
- R7: A stop or a repeated start ends the transfer, and the next transfer writes from data byte 0 again.
- R8: A byte cut off by a stop before its eighth bit changes no output.
- R9: While `out_en_i` is high, an enabled output is high exactly when `ref_clk_i` is high, and a disabled output stays low.
- R10: The per-output gate enable changes only while `ref_clk_i` is low, so no output produces a runt pulse.
- R11: While `out_en_i` is low, `drv_o` is low (all outputs high impedance) and every clock line is held low. While it is high, `drv_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_clk_i | input | 1 | Reference clock to be distributed |
| scl_i | input | 1 | Serial clock line (idles high) |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| sda_oe_o | output | 1 | High to pull the serial data line low (acknowledge) |
| out_en_i | input | 1 | Global output enable, active high |
| clk_o | output | 18 | Gated clock outputs, bit i is output i |
| drv_o | output | 1 | High when the outputs are driven, low for high impedance |

## Verification
A wrong shift count or a wrong state in the serial slave shows up first on `sda_oe_o`. A missing or misplaced acknowledge becomes visible in the ninth serial clock of the very byte where it goes wrong. A wrong byte index or wrong bit mapping shows up on `clk_o` within a few reference-clock periods after the byte completes: a whole output is either stuck low or runs when it should not. The bench samples every output in the middle of both the high and low phases of the reference clock. Any enable change that is not aligned to the low phase is caught internally, because the gate enable must not move while the reference clock is high.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  localparam int unsigned DEF_NUM_OUT = 18;
  localparam logic [6:0]  DEF_ADDR    = 7'b1101001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } slv_state_e;

  // Bit position inside its byte for output k; a trailing partial byte is top-aligned.
  function automatic int map_bit(input int k, input int n);
    int rem;
    rem = n % 8;
    if ((rem != 0) && ((k / 8) == ((n - 1) / 8))) return 8 - rem + (k % 8);
    return k % 8;
  endfunction

endpackage

// File: rtl/clkfan_sync.sv
module clkfan_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/clkfan_slave.sv
module clkfan_slave
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  ADDR  = DEF_ADDR,
  parameter int unsigned NB    = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             sda_oe_o,
  output logic             byte_vld_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [7:0]       byte_dat_o
);

  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NB);

  slv_state_e       state_q, state_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             vld_q, vld_n;
  logic             oe_q, oe_n;
  logic             scl_q, sda_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    idx_n   = idx_q;
    vld_n   = 1'b0;
    if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      idx_n   = '0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end
          if (scl_fall && cnt_q == 4'd8)
            state_n = (sh_q == {ADDR, 1'b0}) ? ST_ADDR_ACK : ST_SKIP;
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (scl_fall) begin
            state_n = ST_DATA;
            cnt_n   = '0;
            if (state_q == ST_DATA_ACK && idx_q != IDX_MAX) idx_n = idx_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
            vld_n = (cnt_q == 4'd7);
          end
          if (scl_fall && cnt_q == 4'd8) state_n = ST_DATA_ACK;
        end
        default: ;
      endcase
    end
    oe_n = (state_n == ST_ADDR_ACK) || (state_n == ST_DATA_ACK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
      oe_q    <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      idx_q   <= idx_n;
      vld_q   <= vld_n;
      oe_q    <= oe_n;
      scl_q   <= scl_s;
      sda_q   <= sda_s;
    end
  end

  assign sda_oe_o   = oe_q;
  assign byte_vld_o = vld_q;
  assign byte_idx_o = idx_q;
  assign byte_dat_o = sh_q;

endmodule

// File: rtl/clkfan_enreg.sv
module clkfan_enreg
  import clkfan_pkg::*;
#(
  parameter int unsigned NUM_OUT = DEF_NUM_OUT,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_vld_i,
  input  logic [IDX_W-1:0]   byte_idx_i,
  input  logic [7:0]         byte_dat_i,
  output logic [NUM_OUT-1:0] en_o
);

  logic [NUM_OUT-1:0] en_q, en_n;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_bit
    localparam int BYTE = k / 8;
    localparam int POS  = map_bit(k, NUM_OUT);
    assign en_n[k] = (int'(byte_idx_i) == BYTE) ? byte_dat_i[POS] : en_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= '1;
    else if (byte_vld_i) en_q <= en_n;
  end

  assign en_o = en_q;

endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate #(
  parameter int unsigned NUM_OUT = 18
) (
  input  logic               ref_clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OUT-1:0] en_i,
  input  logic               out_en_i,
  output logic [NUM_OUT-1:0] gate_en_o,
  output logic [NUM_OUT-1:0] clk_o
);

  logic rst_r1_q, rst_r2_q;
  logic [NUM_OUT-1:0] s1_q, s2_q;

  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_r1_q <= 1'b0;
      rst_r2_q <= 1'b0;
    end else begin
      rst_r1_q <= 1'b1;
      rst_r2_q <= rst_r1_q;
    end
  end

  always_ff @(negedge ref_clk_i or negedge rst_r2_q) begin
    if (!rst_r2_q) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= en_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign clk_o[i] = ref_clk_i & out_en_i & s2_q[i];
  end

  assign gate_en_o = s2_q;

endmodule

// File: rtl/clkfan_ctl.sv
module clkfan_ctl
  import clkfan_pkg::*;
#(
  parameter int unsigned NUM_OUT = DEF_NUM_OUT,
  parameter logic [6:0]  ADDR    = DEF_ADDR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               out_en_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic               drv_o
);

  localparam int unsigned NB    = (NUM_OUT + 7) / 8;
  localparam int unsigned IDX_W = $clog2(NB + 1);

  logic               rst_n_s;
  logic [1:0]         line_s;
  logic               scl_s, sda_s;
  logic               byte_vld;
  logic [IDX_W-1:0]   byte_idx;
  logic [7:0]         byte_dat;
  logic [NUM_OUT-1:0] en_q, gate_en;

  clkfan_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i, .rst_ni, .d_i(1'b1), .q_o(rst_n_s)
  );

  clkfan_sync #(.W(2), .RST_VAL(2'b11)) u_line_sync (
    .clk_i, .rst_ni(rst_n_s), .d_i({scl_i, sda_i}), .q_o(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  clkfan_slave #(.ADDR(ADDR), .NB(NB), .IDX_W(IDX_W)) u_slave (
    .clk_i, .rst_ni(rst_n_s), .scl_s, .sda_s, .sda_oe_o,
    .byte_vld_o(byte_vld), .byte_idx_o(byte_idx), .byte_dat_o(byte_dat)
  );

  clkfan_enreg #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_enreg (
    .clk_i, .rst_ni(rst_n_s), .byte_vld_i(byte_vld), .byte_idx_i(byte_idx),
    .byte_dat_i(byte_dat), .en_o(en_q)
  );

  clkfan_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .ref_clk_i, .rst_ni, .en_i(en_q), .out_en_i, .gate_en_o(gate_en), .clk_o
  );

  assign drv_o = out_en_i;

endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
  parameter int unsigned N     = 18,
  parameter int unsigned NB    = 3,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_clk_i,
  input logic             scl_s,
  input logic             sda_s,
  input logic             sda_oe_o,
  input logic             byte_vld,
  input logic [IDX_W-1:0] byte_idx,
  input logic [N-1:0]     en_q,
  input logic [N-1:0]     gate_en
);

  logic scl_p, sda_p;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // R8
  no_partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld |=> $stable(en_q));

  // R6
  discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld && int'(byte_idx) >= NB) |=> $stable(en_q));

  // R10
  runt_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_clk_i && $past(ref_clk_i)) |-> $stable(gate_en));

  // R2
  ack_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  // R7
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && scl_p && !sda_p && sda_s) |=> !sda_oe_o);

endmodule

bind clkfan_ctl clkfan_chk #(.N(NUM_OUT), .NB(NB), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_clk_i(ref_clk_i), .scl_s(scl_s),
  .sda_s(sda_s), .sda_oe_o(sda_oe_o), .byte_vld(byte_vld),
  .byte_idx(byte_idx), .en_q(en_q), .gate_en(gate_en)
);

// File: tb/tb_clkfan_ctl.sv
`timescale 1ns/1ps
module tb_clkfan_ctl;

  localparam int Q = 10;

  logic        clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic        scl = 1'b1, sda_m = 1'b1, out_en = 1'b1;
  logic        sda_line, sda_oe, drv;
  logic [17:0] clk_o;
  logic [17:0] model = '1;
  int checks = 0, fails = 0;
  bit done = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #2  clk = ~clk;
  always #21 ref_clk = ~ref_clk;

  clkfan_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .scl_i(scl),
    .sda_i(sda_line), .sda_oe_o(sda_oe), .out_en_i(out_en),
    .clk_o(clk_o), .drv_o(drv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void apply(input int idx, input logic [7:0] d);
    if (idx == 0) model[7:0] = d;
    else if (idx == 1) model[15:8] = d;
    else if (idx == 2) model[17:16] = d[7:6];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i_start();
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic i_stop();
    sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic i_bit(input logic b);
    sda_m = b; tick(Q); scl = 1; tick(2 * Q); scl = 0; tick(Q);
  endtask

  task automatic i_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) i_bit(b[i]);
    sda_m = 1; tick(Q); scl = 1; tick(Q); ack = ~sda_line; tick(Q); scl = 0; tick(Q);
  endtask

  // One transfer ending in a stop; updates the model and checks acknowledges.
  task automatic xfer(input logic [7:0] addr, input int n, input logic [7:0] d [6]);
    logic ack;
    bit   ok;
    ok = (addr == 8'hD2);
    i_start();
    i_byte(addr, ack);
    chk(ok ? "R2 addr ack" : "R3 addr nack", 32'(ack), 32'(ok));
    for (int i = 0; i < n; i++) begin
      i_byte(d[i], ack);
      chk(i >= 3 ? "R6 data ack" : "R2 data ack", 32'(ack), 32'(ok));
      if (ok) apply(i, d[i]);
    end
    i_stop();
  endtask

  task automatic check_outs(input string req);
    repeat (6) @(posedge ref_clk);
    #4;
    chk({req, " R9/R10 high phase"}, 32'(clk_o), 32'(model & {18{out_en}}));
    chk({req, " R11 drive"}, 32'(drv), 32'(out_en));
    @(negedge ref_clk);
    #4;
    chk({req, " R9 low phase"}, 32'(clk_o), 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [6];
    logic       ack;
    void'($urandom(32'd4711));
    tick(5);
    rst_n = 1;
    tick(5);

    check_outs("R1 reset");

    d = '{8'hA5, 8'h3C, 8'h80, 8'h00, 8'h00, 8'h00};
    xfer(8'hD2, 3, d);
    check_outs("R4 bytes0-2");

    d = '{8'h5A, 8'hC3, 8'h7F, 8'h00, 8'h00, 8'h00};
    xfer(8'hD2, 3, d);
    check_outs("R5 reserved bits");

    d = '{8'h11, 8'h22, 8'hC0, 8'h00, 8'hFF, 8'h00};
    xfer(8'hD2, 5, d);
    check_outs("R6 extra bytes");

    d = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    xfer(8'hD0, 2, d);
    check_outs("R3 wrong address");
    xfer(8'hD3, 2, d);
    check_outs("R3 read request");

    // R8: byte cut short after four bits
    i_start();
    i_byte(8'hD2, ack);
    chk("R8 addr ack", 32'(ack), 32'd1);
    for (int i = 0; i < 4; i++) i_bit(1'b0);
    i_stop();
    check_outs("R8 partial byte");

    // R7: repeated start restarts at byte 0
    i_start();
    i_byte(8'hD2, ack);
    i_byte(8'h0F, ack);
    apply(0, 8'h0F);
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
    i_byte(8'hD2, ack);
    chk("R7 addr ack after restart", 32'(ack), 32'd1);
    i_byte(8'hF0, ack);
    apply(0, 8'hF0);
    i_stop();
    check_outs("R7 repeated start");

    out_en = 0;
    check_outs("R11 disabled");
    out_en = 1;
    check_outs("R11 restored");

    for (int t = 0; t < 24; t++) begin
      logic [7:0] a;
      int n;
      a = ($urandom_range(0, 4) == 0) ? 8'($urandom_range(0, 255)) : 8'hD2;
      n = $urandom_range(1, 5);
      for (int i = 0; i < 6; i++) d[i] = 8'($urandom_range(0, 255));
      xfer(a, n, d);
      check_outs("R4 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule